// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block steps a converter core through its calibration. The core delivers one result for each pulse on a conversion-done strobe. The sequencer counts those pulses and does three things as it goes: it steers the analog front end, it latches selected results into three calibration registers (offset, positive full scale, negative full scale), and it raises a one-cycle data-ready pulse when the calibration is finished. It does not do the modulation, the filtering or the correction arithmetic. The surrounding logic does those.

Two procedures are available:

- **Combined calibration.** The first conversion after start measures the zero point at the external input. The block then disconnects the inputs and switches in the reference, first in its normal orientation and then reversed. It allows a fixed number of conversions at each step for the filter to settle.
- **System gain calibration.** The block measures the applied full-scale input. It then inverts the input internally and measures it again.

A reserved mode code is accepted without protection and does nothing.

Top module: `cal_seq_top`

## Requirements
- R1: After reset: `busy`, `data_ready` and `cal_err` are low; the front end is in its normal state (`in_connect`=1, `ref_connect`=0, `pol_invert`=0); all write enables are low; all three calibration registers read zero.
- R2: Combined mode is mode code 2'b00. The first `conv_done` after an accepted start loads `conv_result` into `offset_cal`, and `wr_offset` pulses in the cycle after that strobe.
- R3: After the offset capture, the combined mode drives `in_connect`=0, `ref_connect`=1 and `pol_invert`=0. The STEP_CONVS-th (default 3) conversion of this step is loaded into `pos_fs_cal`, and `wr_pos_fs` pulses.
- R4: Next, the combined mode keeps the reference connected and sets `pol_invert`=1. The STEP_CONVS-th conversion of this step is loaded into `neg_fs_cal`, and `wr_neg_fs` pulses.
- R5: After the negative capture, the combined mode reconnects the inputs with normal polarity. It raises `data_ready` for one cycle after STEP_CONVS further conversions.
- R6: System gain mode is mode code 2'b01. Its first conversion is loaded into `neg_fs_cal`. The block then drives `pol_invert`=1 with the inputs still connected, and the next conversion is loaded into `pos_fs_cal`.
- R7: In system gain mode, `data_ready` pulses for one cycle after GAIN_TAIL (default 1) further conversions following the positive capture.
- R8: A combined-mode start with `gain_is_one` low raises `cal_err` for one cycle. No register is written and the block stays idle.
- R9: Mode codes 2'b10 and 2'b11 are reserved. A start with either code writes nothing, raises neither `data_ready` nor `cal_err`, and leaves `busy` low.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `data_ready` is high, and is low in that cycle. A start pulse while busy has no effect on the sequence.
- R11: When a sequence ends, the front end returns to `in_connect`=1, `ref_connect`=0, `pol_invert`=0.
- R12: Each write enable is a single-cycle pulse that follows a `conv_done` cycle. At most one write enable is high at a time. `conv_done` pulses while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_start | input | 1 | One-cycle request to begin a calibration |
| cal_mode | input | 2 | Procedure select: 00 combined, 01 system gain, 10/11 reserved |
| gain_is_one | input | 1 | High when the programmed gain is one |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is present |
| conv_result | input | DW | Result that goes with `conv_done` |
| busy | output | 1 | Calibration in progress |
| data_ready | output | 1 | One-cycle pulse: calibration finished |
| cal_err | output | 1 | One-cycle pulse: combined mode refused because gain is not one |
| in_connect | output | 1 | External inputs connected to the converter |
| ref_connect | output | 1 | Reference switched across the converter inputs |
| pol_invert | output | 1 | Front-end polarity reversed |
| wr_offset | output | 1 | Offset register written |
| wr_pos_fs | output | 1 | Positive full-scale register written |
| wr_neg_fs | output | 1 | Negative full-scale register written |
| offset_cal | output | DW | Offset calibration register |
| pos_fs_cal | output | DW | Positive full-scale calibration register |
| neg_fs_cal | output | DW | Negative full-scale calibration register |

## Verification
The bench builds the block with DW=24, STEP_CONVS=3 and GAIN_TAIL=1. With these values every count boundary falls within a few dozen cycles:

- the third-conversion captures in the two reference steps;
- the three-conversion tail of the combined mode;
- the one-conversion tail of the gain mode.

Giving each conversion a distinct result shows that each register took the right strobe and not a neighbour. Strobes arriving on consecutive cycles exercise the counter with no gaps between conversions.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFFS,
    ST_POS,
    ST_NEG,
    ST_CTAIL,
    ST_GNEG,
    ST_GPOS,
    ST_GTAIL
  } cal_state_e;

  localparam logic [1:0] MODE_COMBINED = 2'b00;
  localparam logic [1:0] MODE_SYSGAIN  = 2'b01;

  localparam int IDX_OFF = 0;
  localparam int IDX_POS = 1;
  localparam int IDX_NEG = 2;
  localparam int NUM_CAL = 3;

endpackage

// File: rtl/cal_conv_count.sv
module cal_conv_count #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/cal_cap_regs.sv
module cal_cap_regs #(
  parameter int DW   = 24,
  parameter int NREG = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          cap_en,
  input  logic [DW-1:0]            d,
  output logic [NREG-1:0][DW-1:0]  q
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= '0;
      else if (cap_en[i]) q[i] <= d;
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en[i] |=> (q[i] == $past(d)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[i] |=> $stable(q[i]));
  end

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_seq_pkg::*;
#(
  parameter int CW         = 2,
  parameter int STEP_CONVS = 3,
  parameter int GAIN_TAIL  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic                 gain_one,
  input  logic                 conv_done,
  input  logic [CW-1:0]        cnt,
  output logic                 cnt_clr,
  output logic [NUM_CAL-1:0]   cap_en,
  output logic [NUM_CAL-1:0]   wr,
  output logic                 data_ready,
  output logic                 err,
  output logic                 busy,
  output logic                 in_connect,
  output logic                 ref_connect,
  output logic                 pol_invert
);

  localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CONVS - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(GAIN_TAIL - 1);
  localparam logic [CW-1:0] ONE_LAST  = '0;

  cal_state_e           state, state_nxt;
  logic [CW-1:0]        last_idx;
  logic                 step_end;
  logic [NUM_CAL-1:0]   wr_nxt;
  logic                 dr_nxt, err_nxt;

  always_comb begin
    case (state)
      ST_POS, ST_NEG, ST_CTAIL: last_idx = STEP_LAST;
      ST_GTAIL:                 last_idx = TAIL_LAST;
      default:                  last_idx = ONE_LAST;
    endcase
  end

  assign step_end = conv_done && (state != ST_IDLE) && (cnt == last_idx);
  assign cnt_clr  = step_end || (state == ST_IDLE);

  always_comb begin
    state_nxt = state;
    wr_nxt    = '0;
    dr_nxt    = 1'b0;
    err_nxt   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (mode == MODE_COMBINED) begin
            if (gain_one) state_nxt = ST_OFFS;
            else          err_nxt   = 1'b1;
          end else if (mode == MODE_SYSGAIN) begin
            state_nxt = ST_GNEG;
          end
        end
      end
      ST_OFFS:  if (step_end) begin state_nxt = ST_POS;   wr_nxt[IDX_OFF] = 1'b1; end
      ST_POS:   if (step_end) begin state_nxt = ST_NEG;   wr_nxt[IDX_POS] = 1'b1; end
      ST_NEG:   if (step_end) begin state_nxt = ST_CTAIL; wr_nxt[IDX_NEG] = 1'b1; end
      ST_GNEG:  if (step_end) begin state_nxt = ST_GPOS;  wr_nxt[IDX_NEG] = 1'b1; end
      ST_GPOS:  if (step_end) begin state_nxt = ST_GTAIL; wr_nxt[IDX_POS] = 1'b1; end
      ST_CTAIL, ST_GTAIL: if (step_end) begin state_nxt = ST_IDLE; dr_nxt = 1'b1; end
      default:  state_nxt = ST_IDLE;
    endcase
  end

  assign cap_en = wr_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wr         <= '0;
      data_ready <= 1'b0;
      err        <= 1'b0;
    end else begin
      state      <= state_nxt;
      wr         <= wr_nxt;
      data_ready <= dr_nxt;
      err        <= err_nxt;
    end
  end

  always_comb begin
    in_connect  = 1'b1;
    ref_connect = 1'b0;
    pol_invert  = 1'b0;
    case (state)
      ST_POS:  begin in_connect = 1'b0; ref_connect = 1'b1; end
      ST_NEG:  begin in_connect = 1'b0; ref_connect = 1'b1; pol_invert = 1'b1; end
      ST_GPOS: pol_invert = 1'b1;
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  assert_dr_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> !busy);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !conv_done) |=> $stable(state));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && (wr == '0)));

  assert_wr_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr));

  assert_end_dr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> data_ready);

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int DW         = 24,
  parameter int STEP_CONVS = 3,
  parameter int GAIN_TAIL  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_start,
  input  logic [1:0]    cal_mode,
  input  logic          gain_is_one,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_result,
  output logic          busy,
  output logic          data_ready,
  output logic          cal_err,
  output logic          in_connect,
  output logic          ref_connect,
  output logic          pol_invert,
  output logic          wr_offset,
  output logic          wr_pos_fs,
  output logic          wr_neg_fs,
  output logic [DW-1:0] offset_cal,
  output logic [DW-1:0] pos_fs_cal,
  output logic [DW-1:0] neg_fs_cal
);

  localparam int MAXN = (STEP_CONVS > GAIN_TAIL) ? STEP_CONVS : GAIN_TAIL;
  localparam int CW   = (MAXN > 1) ? $clog2(MAXN) : 1;

  logic [1:0]                   rst_sync;
  logic                         rst_int_n;
  logic [CW-1:0]                cnt;
  logic                         cnt_clr;
  logic [NUM_CAL-1:0]           cap_en, wr;
  logic [NUM_CAL-1:0][DW-1:0]   cal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cal_conv_count #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cnt_clr),
    .inc   (conv_done),
    .cnt   (cnt)
  );

  cal_seq_fsm #(
    .CW         (CW),
    .STEP_CONVS (STEP_CONVS),
    .GAIN_TAIL  (GAIN_TAIL)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (cal_start),
    .mode        (cal_mode),
    .gain_one    (gain_is_one),
    .conv_done   (conv_done),
    .cnt         (cnt),
    .cnt_clr     (cnt_clr),
    .cap_en      (cap_en),
    .wr          (wr),
    .data_ready  (data_ready),
    .err         (cal_err),
    .busy        (busy),
    .in_connect  (in_connect),
    .ref_connect (ref_connect),
    .pol_invert  (pol_invert)
  );

  cal_cap_regs #(.DW(DW), .NREG(NUM_CAL)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap_en),
    .d      (conv_result),
    .q      (cal_q)
  );

  assign wr_offset  = wr[IDX_OFF];
  assign wr_pos_fs  = wr[IDX_POS];
  assign wr_neg_fs  = wr[IDX_NEG];
  assign offset_cal = cal_q[IDX_OFF];
  assign pos_fs_cal = cal_q[IDX_POS];
  assign neg_fs_cal = cal_q[IDX_NEG];

  assert_wr_after_conv_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_offset || wr_pos_fs || wr_neg_fs) |-> $past(conv_done));

  assert_ref_steer_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ref_connect |-> (!in_connect && busy));

  assert_idle_normal_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> (in_connect && !ref_connect && !pol_invert));

endmodule

// File: tb/sim_cal_seq_top.sv
module sim_cal_seq_top;

  localparam int DW    = 24;
  localparam int STEPN = 3;
  localparam int GTAIL = 1;

  typedef struct {
    int  n;
    int  tgt;
    bit  inc;
    bit  rc;
    bit  inv;
  } step_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_start = 1'b0;
  logic [1:0]    cal_mode = 2'b00;
  logic          gain_is_one = 1'b1;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_result = '0;
  logic          busy, data_ready, cal_err, in_connect, ref_connect, pol_invert;
  logic          wr_offset, wr_pos_fs, wr_neg_fs;
  logic [DW-1:0] offset_cal, pos_fs_cal, neg_fs_cal;

  int checks = 0;
  int fails  = 0;
  bit compare_on = 1'b0;
  int cyc = 0;

  step_t         q[$];
  int            m_cnt = 0;
  bit            e_dr = 0, e_err = 0;
  bit [2:0]      e_wr = 0;
  logic [DW-1:0] e_reg [3] = '{default: '0};

  always #10 clk = ~clk;

  cal_seq_top #(.DW(DW), .STEP_CONVS(STEPN), .GAIN_TAIL(GTAIL)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_mode(cal_mode),
    .gain_is_one(gain_is_one), .conv_done(conv_done), .conv_result(conv_result),
    .busy(busy), .data_ready(data_ready), .cal_err(cal_err),
    .in_connect(in_connect), .ref_connect(ref_connect), .pol_invert(pol_invert),
    .wr_offset(wr_offset), .wr_pos_fs(wr_pos_fs), .wr_neg_fs(wr_neg_fs),
    .offset_cal(offset_cal), .pos_fs_cal(pos_fs_cal), .neg_fs_cal(neg_fs_cal)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference: a queue of pending steps (0 off, 1 pos, 2 neg, 3 done)
  always @(posedge clk) begin
    cyc++;
    e_dr  = 0;
    e_err = 0;
    e_wr  = 0;
    if (compare_on) begin
      if (q.size() == 0) begin
        if (cal_start) begin
          if (cal_mode == 2'b00) begin
            if (gain_is_one) begin
              q.push_back('{1, 0, 1, 0, 0});
              q.push_back('{STEPN, 1, 0, 1, 0});
              q.push_back('{STEPN, 2, 0, 1, 1});
              q.push_back('{STEPN, 3, 1, 0, 0});
            end else e_err = 1;
          end else if (cal_mode == 2'b01) begin
            q.push_back('{1, 2, 1, 0, 0});
            q.push_back('{1, 1, 1, 0, 1});
            q.push_back('{GTAIL, 3, 1, 0, 0});
          end
          m_cnt = 0;
        end
      end else if (conv_done) begin
        m_cnt++;
        if (m_cnt == q[0].n) begin
          if (q[0].tgt == 3) e_dr = 1;
          else begin
            e_wr[q[0].tgt] = 1;
            e_reg[q[0].tgt] = conv_result;
          end
          m_cnt = 0;
          void'(q.pop_front());
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      bit eb, ei, er, ev;
      eb = (q.size() != 0);
      ei = eb ? q[0].inc : 1'b1;
      er = eb ? q[0].rc  : 1'b0;
      ev = eb ? q[0].inv : 1'b0;
      chk(busy == eb, "R10 busy", busy, eb);
      chk(data_ready == e_dr, "R5/R7 data_ready", data_ready, e_dr);
      chk(cal_err == e_err, "R8 cal_err", cal_err, e_err);
      chk({wr_neg_fs, wr_pos_fs, wr_offset} == e_wr, "R12 write enables",
          {wr_neg_fs, wr_pos_fs, wr_offset}, e_wr);
      chk({in_connect, ref_connect, pol_invert} == {ei, er, ev}, "R3/R4/R6/R11 steering",
          {in_connect, ref_connect, pol_invert}, {ei, er, ev});
      chk(offset_cal == e_reg[0], "R2 offset_cal", offset_cal, e_reg[0]);
      chk(pos_fs_cal == e_reg[1], "R3/R6 pos_fs_cal", pos_fs_cal, e_reg[1]);
      chk(neg_fs_cal == e_reg[2], "R4/R6 neg_fs_cal", neg_fs_cal, e_reg[2]);
    end
  end

  task automatic start_cal(input logic [1:0] m, input logic g);
    @(negedge clk);
    cal_mode = m; gain_is_one = g; cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
  endtask

  task automatic conv(input logic [DW-1:0] v, input int gap);
    @(negedge clk);
    conv_done = 1'b1; conv_result = v;
    @(negedge clk);
    conv_done = 1'b0; conv_result = '0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !data_ready && !cal_err, "R1 status idle", {busy, data_ready, cal_err}, 0);
    chk(in_connect && !ref_connect && !pol_invert, "R1 steering normal",
        {in_connect, ref_connect, pol_invert}, 3'b100);
    chk(offset_cal == 0 && pos_fs_cal == 0 && neg_fs_cal == 0, "R1 registers zero",
        offset_cal | pos_fs_cal | neg_fs_cal, 0);
    compare_on = 1'b1;

    // R12 strobe while idle ignored
    conv(24'hDEAD01, 1);

    // Combined mode, R2-R5, R10 start during busy
    start_cal(2'b00, 1'b1);
    chk(busy, "R10 busy after start", busy, 1);
    for (int i = 1; i <= 10; i++) begin
      if (i == 3) start_cal(2'b01, 1'b1);
      conv(24'h100000 + DW'(i), i % 3);
    end
    idle_cycles(2);
    chk(offset_cal == 24'h100001, "R2 offset first conv", offset_cal, 24'h100001);
    chk(pos_fs_cal == 24'h100004, "R3 pos third conv", pos_fs_cal, 24'h100004);
    chk(neg_fs_cal == 24'h100007, "R4 neg third conv", neg_fs_cal, 24'h100007);

    // System gain mode, R6 R7, back-to-back strobes
    start_cal(2'b01, 1'b0);
    @(negedge clk);
    conv_done = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      conv_result = 24'h200000 + DW'(i);
      @(negedge clk);
    end
    conv_done = 1'b0;
    idle_cycles(2);
    chk(neg_fs_cal == 24'h200001, "R6 neg first conv", neg_fs_cal, 24'h200001);
    chk(pos_fs_cal == 24'h200002, "R6 pos second conv", pos_fs_cal, 24'h200002);
    chk(offset_cal == 24'h100001, "R6 offset untouched", offset_cal, 24'h100001);

    // R8 combined mode refused when gain not one
    start_cal(2'b00, 1'b0);
    conv(24'h300001, 1);
    chk(!busy, "R8 stays idle", busy, 0);
    chk(offset_cal == 24'h100001, "R8 no offset write", offset_cal, 24'h100001);

    // R9 reserved codes
    start_cal(2'b10, 1'b1);
    conv(24'h400001, 1);
    start_cal(2'b11, 1'b1);
    conv(24'h400002, 1);
    chk(!busy && !data_ready, "R9 reserved no-op", busy, 0);
    chk(pos_fs_cal == 24'h200002 && neg_fs_cal == 24'h200001, "R9 registers unchanged",
        pos_fs_cal, 24'h200002);

    // Second combined run with dense strobes, R11 end steering
    start_cal(2'b00, 1'b1);
    for (int i = 1; i <= 10; i++) conv(24'h500000 + DW'(i), 0);
    idle_cycles(2);
    chk(in_connect && !ref_connect && !pol_invert, "R11 normal after end",
        {in_connect, ref_connect, pol_invert}, 3'b100);
    chk(neg_fs_cal == 24'h500007, "R4 neg second run", neg_fs_cal, 24'h500007);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule